// File: doc/BRIEF.md
# SWD Transfer Sequencer

This block carries out one complete Serial Wire Debug access. It does not toggle the wire itself. It breaks the access into primitive commands and hands them to a bit engine. Each command says whether the engine drives bits, releases the line for a number of clocks, or samples bits, and it gives the bit count. The engine runs one command at a time and pulses a completion strobe when it is finished. For sample commands it returns the captured bits with that strobe.

A transfer is launched with a start pulse. The pulse carries the request header fields (port select, read/write flag, two register-address bits), the write word, the turnaround length, the number of trailing idle clocks, and a flag that asks for dummy data phases after WAIT or FAULT. The acknowledge is taken from a single sample command that also spans the turnaround clocks. The sequencer then goes down the read, write, dummy or back-off path. It generates and checks even parity on the 32-bit data word. It reports a result code, the raw acknowledge and the read word together with a one-cycle done pulse.

Top module: `swd_xfer_seq`

## Requirements
- R1: Every transfer begins with a drive command of 8 bits. Its bit i is cmd_wdata[i]: bit0=1 (start), bit1=port select, bit2=read flag, bit3=addr[0], bit4=addr[1], bit5=XOR of bits 1..4, bit6=0 (stop), bit7=1 (park).
- R2: The second command samples turnaround+3 bits. The acknowledge is sampled bits turnaround..turnaround+2, with bit i of the sample at op_rdata[i]. It appears on ack_raw. Codes: 3'b001 OK, 3'b010 WAIT, 3'b100 FAULT.
- R3: For an OK read, the block samples 33 bits, then releases the line for turnaround clocks. rdata returns op_rdata[31:0] of the 33-bit sample.
- R4: For an OK write, the block releases for turnaround clocks, then drives 33 bits. cmd_wdata[31:0] holds the write word and cmd_wdata[32] holds the XOR of its 32 bits.
- R5: After an OK access with a non-zero idle count, the block drives zeros in chunks of at most 256 bits. The chunks add up to the idle count. With an idle count of zero, no chunk is issued.
- R6: On WAIT or FAULT with the dummy-phase flag set, a read runs a 33-bit sample followed by a release for turnaround clocks. A write runs the release followed by a 33-bit all-zero drive. No idle chunks follow.
- R7: On WAIT or FAULT with the flag clear, only the turnaround release follows the acknowledge phase.
- R8: The result code is 0 for OK, 1 for WAIT, 2 for FAULT and 3 for any other acknowledge. It is 4 when an OK read's bit 32 differs from the XOR of bits 31:0.
- R9: done pulses for exactly one cycle, in the cycle after the last command's op_done. res_code, ack_raw and rdata stay unchanged from then until the next start. rdata is zero unless the access was an OK read.
- R10: A start pulse that arrives while busy is high has no effect on the running sequence. No command is offered while busy is low.
- R11: Command encoding: cmd_kind 0 = drive, 1 = release, 2 = sample, and cmd_cnt = bit count − 1. An offered command stays stable until cmd_ready is high. The next command is offered only after op_done.
- R12: For any acknowledge other than OK, WAIT or FAULT, the block samples turnaround+33 bits to back off, and then the transfer ends.
- R13: After reset, busy, done and cmd_valid are low and res_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transfer (taken only when idle) |
| req_apndp | input | 1 | Port select bit of the request |
| req_rnw | input | 1 | 1 = read access, 0 = write access |
| req_addr | input | 2 | Register address bits |
| wdata | input | 32 | Word to write |
| trn_len | input | 3 | Turnaround clocks, 1 to 4 |
| idle_cycles | input | 16 | Idle clocks after an OK access |
| dummy_on_fault | input | 1 | Run dummy data phases on WAIT/FAULT |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 3 | Result code (see R8) |
| ack_raw | output | 3 | Acknowledge as sampled |
| rdata | output | 32 | Read word |
| cmd_valid | output | 1 | Command offered to the bit engine |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_kind | output | 2 | 0 drive, 1 release, 2 sample |
| cmd_cnt | output | 8 | Bit count minus one |
| cmd_wdata | output | 33 | Bits to drive, bit 0 first |
| op_done | input | 1 | Bit engine finished the command |
| op_rdata | input | 33 | Sampled bits, bit 0 first |

## Verification
The bench uses the default parameters: a 32-bit word, an 8-bit count field and a 16-bit idle count. The count field caps a chunk at 256 clocks, so idle counts of 256, 257 and 600 reach the exact cap, one clock past it, and several chunks with a short tail. The 3-bit turnaround input lets the bench use lengths of 1 and 4. Garbage ones are placed in the turnaround slots of the acknowledge sample, so a wrong shift is exposed. The bench also stalls cmd_ready on a repeating pattern to exercise the command hold.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

    typedef enum logic [1:0] {
        CMD_DRIVE   = 2'd0,
        CMD_RELEASE = 2'd1,
        CMD_SAMPLE  = 2'd2
    } cmd_kind_e;

    typedef enum logic [3:0] {
        PH_REQ,
        PH_ACK,
        PH_RDAT,
        PH_TRN_RD,
        PH_TRN_WR,
        PH_WDAT,
        PH_IDLE,
        PH_DUMMY_RD,
        PH_DUMMY_TRN,
        PH_DUMMY_WR,
        PH_BACKOFF
    } phase_e;

    typedef enum logic [1:0] {
        ACK_IS_OK,
        ACK_IS_WAIT,
        ACK_IS_FAULT,
        ACK_IS_BAD
    } ack_cls_e;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_WAIT     = 3'd1,
        RES_FAULT    = 3'd2,
        RES_PROTOCOL = 3'd3,
        RES_PARITY   = 3'd4
    } result_e;

    localparam logic [2:0] ACK_CODE_OK    = 3'b001;
    localparam logic [2:0] ACK_CODE_WAIT  = 3'b010;
    localparam logic [2:0] ACK_CODE_FAULT = 3'b100;

    typedef struct packed {
        logic       apndp;
        logic       rnw;
        logic [1:0] addr;
    } req_hdr_t;

    // Header byte, bit 0 goes on the wire first.
    function automatic logic [7:0] req_packet(req_hdr_t h);
        logic par;
        par = h.apndp ^ h.rnw ^ h.addr[0] ^ h.addr[1];
        return {1'b1, 1'b0, par, h.addr[1], h.addr[0], h.rnw, h.apndp, 1'b1};
    endfunction

endpackage

// File: rtl/swd_ack_decode.sv
module swd_ack_decode
    import swd_seq_pkg::*;
#(
    parameter int RD_W  = 33,
    parameter int TRN_W = 3
) (
    input  logic [RD_W-1:0]  sample,
    input  logic [TRN_W-1:0] trn,
    output logic [2:0]       ack,
    output ack_cls_e         cls
);
    // Turnaround bits come first in the sample; the code sits above them.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            ack[i] = sample[int'(trn) + i];
        end
    end

    always_comb begin
        case (ack)
            ACK_CODE_OK:    cls = ACK_IS_OK;
            ACK_CODE_WAIT:  cls = ACK_IS_WAIT;
            ACK_CODE_FAULT: cls = ACK_IS_FAULT;
            default:        cls = ACK_IS_BAD;
        endcase
    end
endmodule

// File: rtl/swd_idle_chunker.sv
module swd_idle_chunker #(
    parameter int IDLE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDLE_W-1:0] load_val,
    input  logic              step,
    output logic [CNT_W-1:0]  chunk_m1,
    output logic              last,
    output logic              empty
);
    localparam int           CHUNK_MAX = 1 << CNT_W;
    localparam logic [IDLE_W:0] CAP    = (IDLE_W+1)'(CHUNK_MAX);

    logic [IDLE_W-1:0] rem_q;
    logic [IDLE_W:0]   rem_ext;
    logic [IDLE_W:0]   chunk;

    assign rem_ext  = {1'b0, rem_q};
    assign last     = (rem_ext <= CAP);
    assign chunk    = last ? rem_ext : CAP;
    assign chunk_m1 = CNT_W'(chunk - 1'b1);
    assign empty    = (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (step) begin
            rem_q <= rem_q - chunk[IDLE_W-1:0];
        end
    end
endmodule

// File: rtl/swd_cmd_form.sv
module swd_cmd_form
    import swd_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TRN_W  = 3,
    parameter int CNT_W  = 8
) (
    input  phase_e            phase,
    input  req_hdr_t          hdr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  trn,
    input  logic [CNT_W-1:0]  chunk_m1,
    output cmd_kind_e         kind,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W:0]   wbits
);
    localparam logic [CNT_W-1:0] FRAME_M1 = CNT_W'(DATA_W);

    logic [CNT_W-1:0] trn_c;
    assign trn_c = CNT_W'(trn);

    always_comb begin
        kind  = CMD_SAMPLE;
        cnt   = '0;
        wbits = '0;
        case (phase)
            PH_REQ: begin
                kind  = CMD_DRIVE;
                cnt   = CNT_W'(7);
                wbits = (DATA_W+1)'(req_packet(hdr));
            end
            PH_ACK:      cnt = trn_c + CNT_W'(2);
            PH_RDAT,
            PH_DUMMY_RD: cnt = FRAME_M1;
            PH_TRN_RD,
            PH_TRN_WR,
            PH_DUMMY_TRN: begin
                kind = CMD_RELEASE;
                cnt  = trn_c - CNT_W'(1);
            end
            PH_WDAT: begin
                kind  = CMD_DRIVE;
                cnt   = FRAME_M1;
                wbits = {^wdata, wdata};
            end
            PH_IDLE: begin
                kind = CMD_DRIVE;
                cnt  = chunk_m1;
            end
            PH_DUMMY_WR: begin
                kind = CMD_DRIVE;
                cnt  = FRAME_M1;
            end
            PH_BACKOFF:  cnt = trn_c + FRAME_M1;
            default:     cnt = '0;
        endcase
    end
endmodule

// File: rtl/swd_xfer_seq.sv
module swd_xfer_seq
    import swd_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TRN_W  = 3,
    parameter int IDLE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_apndp,
    input  logic              req_rnw,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  trn_len,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic              dummy_on_fault,
    output logic              busy,
    output logic              done,
    output logic [2:0]        res_code,
    output logic [2:0]        ack_raw,
    output logic [DATA_W-1:0] rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [CNT_W-1:0]  cmd_cnt,
    output logic [DATA_W:0]   cmd_wdata,
    input  logic              op_done,
    input  logic [DATA_W:0]   op_rdata
);
    localparam int RD_W = DATA_W + 1;

    logic              busy_q, done_q, issued_q, dummy_q;
    phase_e            phase_q, phase_nxt;
    req_hdr_t          hdr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [TRN_W-1:0]  trn_q;
    logic [2:0]        ack_q;
    result_e           res_q;
    logic              finish;

    logic              launch, op_end;
    logic [2:0]        ack_bits;
    ack_cls_e          ack_cls;
    logic [CNT_W-1:0]  chunk_m1;
    logic              chunk_last, idle_empty;
    cmd_kind_e         kind;

    assign launch = !busy_q && start;
    assign op_end = busy_q && issued_q && op_done;

    swd_ack_decode #(.RD_W(RD_W), .TRN_W(TRN_W)) u_ack (
        .sample (op_rdata),
        .trn    (trn_q),
        .ack    (ack_bits),
        .cls    (ack_cls)
    );

    swd_idle_chunker #(.IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (idle_cycles),
        .step     (op_end && phase_q == PH_IDLE),
        .chunk_m1 (chunk_m1),
        .last     (chunk_last),
        .empty    (idle_empty)
    );

    swd_cmd_form #(.DATA_W(DATA_W), .TRN_W(TRN_W), .CNT_W(CNT_W)) u_form (
        .phase    (phase_q),
        .hdr      (hdr_q),
        .wdata    (wdata_q),
        .trn      (trn_q),
        .chunk_m1 (chunk_m1),
        .kind     (kind),
        .cnt      (cmd_cnt),
        .wbits    (cmd_wdata)
    );

    // Successor of the phase whose command just completed.
    always_comb begin
        phase_nxt = phase_q;
        finish    = 1'b0;
        case (phase_q)
            PH_REQ: phase_nxt = PH_ACK;
            PH_ACK: begin
                case (ack_cls)
                    ACK_IS_OK:    phase_nxt = hdr_q.rnw ? PH_RDAT : PH_TRN_WR;
                    ACK_IS_WAIT,
                    ACK_IS_FAULT: phase_nxt = (dummy_q && hdr_q.rnw) ? PH_DUMMY_RD
                                                                      : PH_DUMMY_TRN;
                    default:      phase_nxt = PH_BACKOFF;
                endcase
            end
            PH_RDAT:     phase_nxt = PH_TRN_RD;
            PH_TRN_WR:   phase_nxt = PH_WDAT;
            PH_TRN_RD,
            PH_WDAT: begin
                if (idle_empty) finish = 1'b1;
                else            phase_nxt = PH_IDLE;
            end
            PH_IDLE:     finish = chunk_last;
            PH_DUMMY_RD: phase_nxt = PH_DUMMY_TRN;
            PH_DUMMY_TRN: begin
                if (dummy_q && !hdr_q.rnw) phase_nxt = PH_DUMMY_WR;
                else                       finish = 1'b1;
            end
            default:     finish = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            issued_q <= 1'b0;
            dummy_q  <= 1'b0;
            phase_q  <= PH_REQ;
            hdr_q    <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            trn_q    <= '0;
            ack_q    <= '0;
            res_q    <= RES_OK;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                busy_q   <= 1'b1;
                issued_q <= 1'b0;
                phase_q  <= PH_REQ;
                hdr_q    <= '{apndp: req_apndp, rnw: req_rnw, addr: req_addr};
                wdata_q  <= wdata;
                trn_q    <= trn_len;
                dummy_q  <= dummy_on_fault;
                ack_q    <= '0;
                rdata_q  <= '0;
                res_q    <= RES_OK;
            end else if (busy_q) begin
                if (cmd_valid && cmd_ready) issued_q <= 1'b1;
                if (op_end) begin
                    issued_q <= 1'b0;
                    phase_q  <= phase_nxt;
                    if (phase_q == PH_ACK) begin
                        ack_q <= ack_bits;
                        case (ack_cls)
                            ACK_IS_OK:    res_q <= RES_OK;
                            ACK_IS_WAIT:  res_q <= RES_WAIT;
                            ACK_IS_FAULT: res_q <= RES_FAULT;
                            default:      res_q <= RES_PROTOCOL;
                        endcase
                    end
                    if (phase_q == PH_RDAT) begin
                        rdata_q <= op_rdata[DATA_W-1:0];
                        if ((^op_rdata[DATA_W-1:0]) != op_rdata[DATA_W])
                            res_q <= RES_PARITY;
                    end
                    if (finish) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign res_code  = res_q;
    assign ack_raw   = ack_q;
    assign rdata     = rdata_q;
    assign cmd_valid = busy_q && !issued_q;
    assign cmd_kind  = kind;
endmodule

// File: rtl/swd_xfer_seq_chk.sv
module swd_xfer_seq_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [2:0]        res_code,
    input logic [2:0]        ack_raw,
    input logic [DATA_W-1:0] rdata,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [CNT_W-1:0]  cmd_cnt,
    input logic [DATA_W:0]   cmd_wdata,
    input logic              op_done
);
    p_done_after_op_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(op_done));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_held_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res_code) && $stable(ack_raw) && $stable(rdata)));

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_kind) && $stable(cmd_cnt) && $stable(cmd_wdata)));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_valid);

    p_launch_from_start_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_ok_code_r8: assert property (@(posedge clk) disable iff (rst)
        (done && res_code == 3'd0) |-> (ack_raw == 3'b001));
endmodule

bind swd_xfer_seq swd_xfer_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .res_code  (res_code),
    .ack_raw   (ack_raw),
    .rdata     (rdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_cnt   (cmd_cnt),
    .cmd_wdata (cmd_wdata),
    .op_done   (op_done)
);

// File: tb/tb_swd_xfer_seq.sv
`timescale 1ns/1ps
module tb_swd_xfer_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        req_apndp = 1'b0;
    logic        req_rnw = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [2:0]  trn_len = 3'd1;
    logic [15:0] idle_cycles = '0;
    logic        dummy_on_fault = 1'b0;
    logic        busy, done;
    logic [2:0]  res_code, ack_raw;
    logic [31:0] rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_kind;
    logic [7:0]  cmd_cnt;
    logic [32:0] cmd_wdata;
    logic        op_done = 1'b0;
    logic [32:0] op_rdata = '0;

    swd_xfer_seq dut (
        .clk(clk), .rst(rst), .start(start), .req_apndp(req_apndp),
        .req_rnw(req_rnw), .req_addr(req_addr), .wdata(wdata),
        .trn_len(trn_len), .idle_cycles(idle_cycles),
        .dummy_on_fault(dummy_on_fault), .busy(busy), .done(done),
        .res_code(res_code), .ack_raw(ack_raw), .rdata(rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_cnt(cmd_cnt), .cmd_wdata(cmd_wdata), .op_done(op_done),
        .op_rdata(op_rdata)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0]  kind;
        logic [7:0]  cnt;
        logic [32:0] wbits;
        string       req;
    } exp_cmd_t;

    exp_cmd_t exp_q[$];

    // Stimulus for the bit engine model
    logic [2:0]  tb_ack   = 3'b001;
    int          tb_trn   = 1;
    logic [31:0] tb_rword = '0;
    logic        tb_rpar  = 1'b0;
    logic        stall_en = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input string req, input logic [1:0] kind,
                            input int bits, input logic [32:0] wb);
        exp_cmd_t e;
        e.kind  = kind;
        e.cnt   = 8'(bits - 1);
        e.wbits = wb;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    // Bit engine model and scoreboard monitor
    int          cyc = 0;
    logic        eng_pend = 1'b0;
    int          eng_lat = 0;
    logic [1:0]  eng_kind = '0;
    logic [7:0]  eng_cnt = '0;

    function automatic logic [32:0] eng_resp(input logic [1:0] k, input logic [7:0] c);
        logic [32:0] v;
        v = '0;
        if (k == 2'd2) begin
            if (c < 8'd32) begin
                v = {30'd0, tb_ack} << tb_trn;
                v = v | ((33'd1 << tb_trn) - 33'd1);
            end else if (c == 8'd32) begin
                v = {tb_rpar, tb_rword};
            end else begin
                v = '1;
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        op_done <= 1'b0;
        if (rst) begin
            eng_pend  <= 1'b0;
            cmd_ready <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                chk("R11", "unexpected command", {54'd0, cmd_kind, cmd_cnt}, 64'hDEAD);
            end else begin
                exp_cmd_t e;
                e = exp_q.pop_front();
                chk(e.req, "cmd_kind", 64'(cmd_kind), 64'(e.kind));
                chk(e.req, "cmd_cnt", 64'(cmd_cnt), 64'(e.cnt));
                if (e.kind == 2'd0)
                    chk(e.req, "cmd_wdata", 64'(cmd_wdata), 64'(e.wbits));
            end
            eng_pend  <= 1'b1;
            eng_lat   <= 2;
            eng_kind  <= cmd_kind;
            eng_cnt   <= cmd_cnt;
            cmd_ready <= 1'b0;
        end else if (eng_pend) begin
            if (eng_lat == 0) begin
                op_done  <= 1'b1;
                op_rdata <= eng_resp(eng_kind, eng_cnt);
                eng_pend <= 1'b0;
            end else begin
                eng_lat <= eng_lat - 1;
            end
        end else begin
            cmd_ready <= !(stall_en && (cyc % 3 == 1));
        end
    end

    // Driver: build the expected command list, launch, then check the result.
    task automatic run_xfer(input string req, input logic apndp, input logic rnw,
                            input logic [1:0] addr, input logic [31:0] wd,
                            input int trn, input int idle, input logic dp,
                            input logic [2:0] ack, input logic [31:0] rword,
                            input logic rpar, input logic poke);
        logic [7:0] pkt;
        logic       ok, wf;
        int         n, c, guard;
        logic [2:0] exp_res;
        logic [31:0] exp_rd;

        tb_ack = ack; tb_trn = trn; tb_rword = rword; tb_rpar = rpar;

        pkt = {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
        push_exp("R1", 2'd0, 8, {25'd0, pkt});
        push_exp("R2", 2'd2, trn + 3, '0);
        ok = (ack == 3'b001);
        wf = (ack == 3'b010) || (ack == 3'b100);
        if (ok) begin
            if (rnw) begin
                push_exp("R3", 2'd2, 33, '0);
                push_exp("R3", 2'd1, trn, '0);
            end else begin
                push_exp("R4", 2'd1, trn, '0);
                push_exp("R4", 2'd0, 33, {^wd, wd});
            end
            n = idle;
            while (n > 0) begin
                c = (n > 256) ? 256 : n;
                push_exp("R5", 2'd0, c, '0);
                n -= c;
            end
        end else if (wf) begin
            if (dp && rnw) push_exp("R6", 2'd2, 33, '0);
            push_exp(dp ? "R6" : "R7", 2'd1, trn, '0);
            if (dp && !rnw) push_exp("R6", 2'd0, 33, '0);
        end else begin
            push_exp("R12", 2'd2, trn + 33, '0);
        end

        if (ok)                 exp_res = (rnw && ((^rword) != rpar)) ? 3'd4 : 3'd0;
        else if (ack == 3'b010) exp_res = 3'd1;
        else if (ack == 3'b100) exp_res = 3'd2;
        else                    exp_res = 3'd3;
        exp_rd = (ok && rnw) ? rword : 32'd0;

        @(negedge clk);
        req_apndp = apndp; req_rnw = rnw; req_addr = addr; wdata = wd;
        trn_len = 3'(trn); idle_cycles = 16'(idle); dummy_on_fault = dp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            chk("R10", "busy before poke", 64'(busy), 64'd1);
            req_rnw = ~rnw; wdata = ~wd; trn_len = 3'd4; idle_cycles = 16'd9;
            req_addr = ~addr; dummy_on_fault = ~dp;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end

        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9", "done seen", 64'(done), 64'd1);
        chk("R9", "all commands issued", 64'(exp_q.size()), 64'd0);
        chk("R8", "res_code", 64'(res_code), 64'(exp_res));
        chk("R2", "ack_raw", 64'(ack_raw), 64'(ack));
        chk(rnw ? "R3" : "R9", "rdata", 64'(rdata), 64'(exp_rd));
        @(negedge clk);
        chk("R9", "done one cycle", 64'(done), 64'd0);
        chk("R9", "res_code held", 64'(res_code), 64'(exp_res));
        chk("R10", "idle after done", 64'(busy), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "busy", 64'(busy), 64'd0);
        chk("R13", "done", 64'(done), 64'd0);
        chk("R13", "cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R13", "res_code", 64'(res_code), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "no command when idle", 64'(cmd_valid), 64'd0);

        // OK read, short turnaround, good parity, no idle
        run_xfer("R3", 1'b1, 1'b1, 2'b01, 32'h0, 1, 0, 1'b0, 3'b001,
                 32'hA5A5_0F0F, ^32'hA5A5_0F0F, 1'b0);
        // OK write with a few idle clocks
        run_xfer("R4", 1'b0, 1'b0, 2'b10, 32'h1234_5679, 2, 3, 1'b0, 3'b001,
                 32'h0, 1'b0, 1'b0);
        // Longest turnaround, read, idle exactly at the chunk cap
        run_xfer("R2", 1'b0, 1'b1, 2'b11, 32'h0, 4, 256, 1'b0, 3'b001,
                 32'h8000_0001, 1'b0, 1'b0);
        // Idle one past the cap, then several chunks
        run_xfer("R5", 1'b1, 1'b0, 2'b00, 32'hFFFF_FFFF, 1, 257, 1'b0, 3'b001,
                 32'h0, 1'b0, 1'b0);
        stall_en = 1'b1;
        run_xfer("R5", 1'b0, 1'b1, 2'b10, 32'h0, 3, 600, 1'b0, 3'b001,
                 32'h0000_0007, 1'b1, 1'b0);
        // WAIT/FAULT with dummy phases
        run_xfer("R6", 1'b1, 1'b1, 2'b01, 32'h0, 1, 5, 1'b1, 3'b010,
                 32'h0, 1'b0, 1'b0);
        run_xfer("R6", 1'b0, 1'b0, 2'b11, 32'hDEAD_BEEF, 3, 5, 1'b1, 3'b100,
                 32'h0, 1'b0, 1'b0);
        // WAIT/FAULT without dummy phases
        run_xfer("R7", 1'b0, 1'b0, 2'b01, 32'h5555_AAAA, 2, 5, 1'b0, 3'b010,
                 32'h0, 1'b0, 1'b0);
        run_xfer("R7", 1'b1, 1'b1, 2'b00, 32'h0, 1, 5, 1'b0, 3'b100,
                 32'h0, 1'b0, 1'b0);
        // Invalid acknowledges
        run_xfer("R12", 1'b0, 1'b1, 2'b10, 32'h0, 2, 5, 1'b1, 3'b111,
                 32'h0, 1'b0, 1'b0);
        run_xfer("R12", 1'b1, 1'b0, 2'b01, 32'h0, 4, 0, 1'b0, 3'b000,
                 32'h0, 1'b0, 1'b0);
        // Parity mismatch on read data
        run_xfer("R8", 1'b1, 1'b1, 2'b11, 32'h0, 1, 2, 1'b0, 3'b001,
                 32'h0000_0003, 1'b1, 1'b0);
        // Start while busy is ignored
        stall_en = 1'b0;
        run_xfer("R10", 1'b0, 1'b0, 2'b10, 32'h0F0F_F0F0, 2, 4, 1'b0, 3'b001,
                 32'h0, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule